// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block is a purely combinational arithmetic and logic unit for a small byte-wide processor datapath. Two operands and a four-bit operation code go in. A result word and four status flags come out: carry, overflow, negative and zero. Every output depends only on the inputs present at that moment.

The upper two bits of the operation code select one of four operation classes: arithmetic, left move, right move and bitwise logic. The lower two bits select the variant within that class. Each class runs in its own unit, and all four units work in parallel. A final multiplexer picks the result, carry and overflow of the selected class. Negative and zero are then derived once, from the selected result. Subtraction has no separate subtractor. It uses the adder with the second operand inverted and the carry-in forced to one.

The operation code has sixteen values but only ten operations. The six unused codes give a result of zero, so every output is defined for every input.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0000 (ADD) gives F = (A + B) mod 256, and C is the carry out of bit 7.
- R2: Opcode 0001 (SUB) gives F = (A + ~B + 1) mod 256, and C is the carry out of bit 7 of that sum. C is therefore 1 exactly when A >= B as unsigned values.
- R3: For ADD and SUB, V is 1 exactly when the carry into bit 7 differs from the carry out of bit 7. This is the same as two's-complement overflow of the signed result.
- R4: Opcode 0100 (LSL) shifts A left by one and puts 0 in bit 0, with C = A[7]. Opcode 1000 (LSR) shifts A right by one and puts 0 in bit 7, with C = A[0]. V is 0 for both.
- R5: Opcode 0101 (RL) rotates A left, so that A[7] goes to bit 0, with C = A[7]. Opcode 1001 (RR) rotates A right, so that A[0] goes to bit 7, with C = A[0]. V is 0 for both.
- R6: Opcodes 1100, 1101, 1110 and 1111 give A AND B, A OR B, A XOR B and NOT A respectively. C and V are 0 for all four.
- R7: For LSL, LSR, RL, RR and NOT, the B operand has no effect on any output.
- R8: For every opcode, N equals bit 7 of F, and Z is 1 exactly when F is zero.
- R9: The unused opcodes 0010, 0011, 0110, 0111, 1010 and 1011 give F = 0x00 with C = 0, V = 0, N = 0 and Z = 1.
- R10: All outputs are a pure function of the current inputs. The block holds no state and needs no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 8 | First operand (W bits) |
| opnd_b | input | 8 | Second operand (W bits) |
| op_sel | input | 4 | Operation code; bits 3:2 select the class, bits 1:0 the variant |
| res | output | 8 | Result F |
| fl_c | output | 1 | Carry flag |
| fl_v | output | 1 | Overflow flag |
| fl_n | output | 1 | Negative flag |
| fl_z | output | 1 | Zero flag |

## Verification
The bench builds the block with its default width of eight bits. At that width all 256 × 256 operand pairs can be applied under each of the sixteen operation codes, about a million vectors. The sweep covers every carry and overflow corner of the adder, every bit that can be moved out by a shift or rotate, and every unused code. It also applies every value of B to the operations that must ignore it. Each result is compared against a reference model written in the bench from the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int OP_W  = 4;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_ARITH = 2'b00,
        CLS_LEFT  = 2'b01,
        CLS_RIGHT = 2'b10,
        CLS_LOGIC = 2'b11
    } op_class_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOT = 2'b11
    } logic_sel_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } cv_t;

    function automatic op_class_e op_class(input logic [OP_W-1:0] op);
        return op_class_e'(op[OP_W-1 -: CLS_W]);
    endfunction

    // Arithmetic, left and right classes use only variants 00 and 01.
    function automatic logic op_defined(input logic [OP_W-1:0] op);
        return (op_class(op) == CLS_LOGIC) || (op[1] == 1'b0);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output cv_t          cv_o
);
    localparam int LOW_W = W - 1;

    logic [W-1:0]   b_eff;
    logic [LOW_W:0] low_sum;
    logic           c_into_msb;
    logic           c_out_msb;
    logic           msb_sum;

    assign b_eff = sub_i ? ~b_i : b_i;

    // Lower bits carry the injected one; the top bit is split out so
    // both carries around it are visible.
    assign low_sum    = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]}
                        + {{LOW_W{1'b0}}, sub_i};
    assign c_into_msb = low_sum[LOW_W];
    assign {c_out_msb, msb_sum} = {1'b0, a_i[W-1]} + {1'b0, b_eff[W-1]}
                                  + {1'b0, c_into_msb};

    assign sum_o      = {msb_sum, low_sum[LOW_W-1:0]};
    assign cv_o.carry = c_out_msb;
    assign cv_o.ovf   = c_into_msb ^ c_out_msb;
endmodule

// File: rtl/alu8_mover.sv
module alu8_mover
    import alu8_pkg::*;
#(
    parameter int W      = 8,
    parameter bit TO_LSB = 1'b0
) (
    input  logic [W-1:0] a_i,
    input  logic         rot_i,
    output logic [W-1:0] out_o,
    output cv_t          cv_o
);
    logic exit_bit;
    logic fill_bit;

    generate
        if (TO_LSB) begin : g_right
            assign exit_bit = a_i[0];
            assign fill_bit = rot_i & exit_bit;
            assign out_o    = {fill_bit, a_i[W-1:1]};
        end else begin : g_left
            assign exit_bit = a_i[W-1];
            assign fill_bit = rot_i & exit_bit;
            assign out_o    = {a_i[W-2:0], fill_bit};
        end
    endgenerate

    assign cv_o.carry = exit_bit;
    assign cv_o.ovf   = 1'b0;
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    output logic [W-1:0] out_o,
    output cv_t          cv_o
);
    always_comb begin
        unique case (sel_i)
            LG_AND:  out_o = a_i & b_i;
            LG_OR:   out_o = a_i | b_i;
            LG_XOR:  out_o = a_i ^ b_i;
            default: out_o = ~a_i;
        endcase
    end

    assign cv_o = '0;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    opnd_b,
    input  logic [OP_W-1:0] op_sel,
    output logic [W-1:0]    res,
    output logic            fl_c,
    output logic            fl_v,
    output logic            fl_n,
    output logic            fl_z
);
    logic [W-1:0] arith_f, left_f, right_f, logic_f;
    cv_t          arith_cv, left_cv, right_cv, logic_cv;
    cv_t          sel_cv;

    alu8_addsub #(.W(W)) u_addsub (
        .a_i(opnd_a), .b_i(opnd_b), .sub_i(op_sel[0]),
        .sum_o(arith_f), .cv_o(arith_cv)
    );

    alu8_mover #(.W(W), .TO_LSB(1'b0)) u_left (
        .a_i(opnd_a), .rot_i(op_sel[0]), .out_o(left_f), .cv_o(left_cv)
    );

    alu8_mover #(.W(W), .TO_LSB(1'b1)) u_right (
        .a_i(opnd_a), .rot_i(op_sel[0]), .out_o(right_f), .cv_o(right_cv)
    );

    alu8_bitwise #(.W(W)) u_logic (
        .a_i(opnd_a), .b_i(opnd_b), .sel_i(logic_sel_e'(op_sel[1:0])),
        .out_o(logic_f), .cv_o(logic_cv)
    );

    always_comb begin
        res    = '0;
        sel_cv = '0;
        if (op_defined(op_sel)) begin
            unique case (op_class(op_sel))
                CLS_ARITH: begin res = arith_f; sel_cv = arith_cv; end
                CLS_LEFT:  begin res = left_f;  sel_cv = left_cv;  end
                CLS_RIGHT: begin res = right_f; sel_cv = right_cv; end
                default:   begin res = logic_f; sel_cv = logic_cv; end
            endcase
        end
    end

    assign fl_c = sel_cv.carry;
    assign fl_v = sel_cv.ovf;
    assign fl_n = res[W-1];
    assign fl_z = ~|res;

    // Behavioural cross-checks against the structural datapath.
    always_comb begin
        if (op_sel == 4'b0000) begin
            p_add_sum_r1: assert ({fl_c, res} == ({1'b0, opnd_a} + {1'b0, opnd_b}));
            p_add_ovf_r3: assert (fl_v == ((opnd_a[W-1] == opnd_b[W-1]) && (res[W-1] != opnd_a[W-1])));
        end
        if (op_sel == 4'b0001) begin
            p_sub_diff_r2: assert (res == W'(opnd_a - opnd_b) && fl_c == (opnd_a >= opnd_b));
            p_sub_ovf_r3:  assert (fl_v == ((opnd_a[W-1] != opnd_b[W-1]) && (res[W-1] != opnd_a[W-1])));
        end
        if (op_sel == 4'b0100) begin
            p_lsl_fill_r4: assert (res[0] == 1'b0 && fl_c == opnd_a[W-1] && !fl_v);
        end
        if (op_sel == 4'b1000) begin
            p_lsr_fill_r4: assert (res[W-1] == 1'b0 && fl_c == opnd_a[0] && !fl_v);
        end
        if (op_sel == 4'b0101) begin
            p_rl_inverse_r5: assert ({res[0], res[W-1:1]} == opnd_a && fl_c == opnd_a[W-1]);
        end
        if (op_sel == 4'b1001) begin
            p_rr_inverse_r5: assert ({res[W-2:0], res[W-1]} == opnd_a && fl_c == opnd_a[0]);
        end
        if (op_sel[3:2] == 2'b11) begin
            p_logic_flags_r6: assert (!fl_c && !fl_v);
        end
        if (!op_defined(op_sel)) begin
            p_unused_zero_r9: assert (res == '0 && !fl_c && !fl_v && !fl_n && fl_z);
        end
    end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/100ps
module sim_alu8_core;
    localparam int W         = 8;
    localparam int WDOG_CYC  = 190000;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [3:0] op;
        logic [7:0] f;
        logic       c, v, n, z;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0] a_s = '0, b_s = '0, f_s;
    logic [3:0] op_s = '0;
    logic       c_s, v_s, n_s, z_s;

    alu8_core #(.W(W)) u0 (
        .opnd_a(a_s), .opnd_b(b_s), .op_sel(op_s),
        .res(f_s), .fl_c(c_s), .fl_v(v_s), .fl_n(n_s), .fl_z(z_s)
    );

    item_t sb_q[$];
    event  drv_ev;
    int    n_vec  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic item_t model(input logic [7:0] a, input logic [7:0] b,
                                    input logic [3:0] op);
        item_t it;
        logic [8:0] s;
        it = '0; it.a = a; it.b = b; it.op = op;
        case (op)
            4'b0000: begin s = a + b; it.f = s[7:0]; it.c = s[8];
                     it.v = (a[7] == b[7]) && (s[7] != a[7]); end
            4'b0001: begin s = {1'b0, a} + {1'b0, ~b} + 9'd1; it.f = s[7:0]; it.c = s[8];
                     it.v = (a[7] != b[7]) && (s[7] != a[7]); end
            4'b0100: begin it.f = {a[6:0], 1'b0}; it.c = a[7]; end
            4'b1000: begin it.f = {1'b0, a[7:1]}; it.c = a[0]; end
            4'b0101: begin it.f = {a[6:0], a[7]}; it.c = a[7]; end
            4'b1001: begin it.f = {a[0], a[7:1]}; it.c = a[0]; end
            4'b1100: it.f = a & b;
            4'b1101: it.f = a | b;
            4'b1110: it.f = a ^ b;
            4'b1111: it.f = ~a;
            default: it.f = 8'h00;
        endcase
        it.n = it.f[7];             // R8
        it.z = (it.f == 8'h00);     // R8
        return it;
    endfunction

    function automatic string req_tag(input logic [3:0] op);
        case (op)
            4'b0000: return "R1,R3,R8";
            4'b0001: return "R2,R3,R8";
            4'b0100, 4'b1000: return "R4,R7,R8";
            4'b0101, 4'b1001: return "R5,R7,R8";
            4'b1111: return "R6,R7,R8";
            4'b1100, 4'b1101, 4'b1110: return "R6,R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
        a_s = a; b_s = b; op_s = op;
        sb_q.push_back(model(a, b, op));
        -> drv_ev;
        #1;
    endtask

    // Monitor: outputs are sampled half a step after each new vector with
    // no clock edge in between, which is what R10 demands.
    initial begin
        forever begin
            @(drv_ev);
            #0.5;
            begin
                item_t e;
                e = sb_q.pop_front();
                n_vec++;
                if ({f_s, c_s, v_s, n_s, z_s} !== {e.f, e.c, e.v, e.n, e.z}) begin
                    n_fail++;
                    $display("FAIL %s (R10) op=%b a=%h b=%h actual F=%h CVNZ=%b%b%b%b expected F=%h CVNZ=%b%b%b%b",
                             req_tag(e.op), e.op, e.a, e.b, f_s, c_s, v_s, n_s, z_s,
                             e.f, e.c, e.v, e.n, e.z);
                end
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        #0.25;
        // Post-reset state: all-zero inputs, ADD, expect F=0 Z=1 (R1, R8).
        drive(8'h00, 8'h00, 4'b0000);
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    drive(8'(a), 8'(b), 4'(op));
                end
            end
        end
        #2;
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WDOG_CYC) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected completion before %0d", cyc, WDOG_CYC);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule